// File: doc/BRIEF.md
# Fixed Off-Time Bridge Chopper

This block regulates the current in one motor winding by chopping a single full bridge. In the drive phase it switches on the diagonal source/sink pair chosen by the polarity input, so current builds through the winding. When an external current comparator reports that the trip level has been reached, the drive phase ends. The bridge then stays in a decay phase for a fixed number of clock cycles, whatever the current does, and afterwards drives again. A two-phase driver uses one instance per winding.

The decay phase recirculates the winding current in one of three ways. In slow decay only the source is released and the sink keeps conducting. In fast decay all four switches are off. In mixed decay the first part of the off period is fast and the rest is slow. The comparator is ignored for a blanking window after every change at the gate outputs, so switching transients cannot end a drive phase early. A hold request (thermal fault, undervoltage or sleep) and an active-low output enable both force all gates off while they are asserted. A dead cycle separates the two switches of a leg whenever one of them turns on.

All timer lengths are clock-cycle parameters. The gate outputs come straight from registers.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all four gate outputs are low.
- R2: In the drive phase the gates are {src_a,snk_a,src_b,snk_b} = 1001 when `polarity_i` is 0 and 0110 when it is 1. With the block enabled, this pattern appears in the second cycle after reset release and holds for as long as no trip is accepted.
- R3: A trip sampled high at a rising edge after blanking has elapsed ends the drive phase. The drive pattern is still present in the following cycle and is replaced by the decay pattern in the cycle after that.
- R4: Slow decay (`decay_i` = 00) keeps only the conducting sink on during the off period: 0001 for polarity 0 and 0100 for polarity 1.
- R5: Fast decay (`decay_i` = 01) holds all four gates low during the off period.
- R6: The off period lasts exactly OFF_CYCLES cycles, whatever `trip_i` does during it.
- R7: Mixed decay (`decay_i` = 10) holds all gates low for the first min(FAST_CYCLES, OFF_CYCLES) cycles of the off period and uses the slow-decay pattern for the rest.
- R8: After every change at the gate outputs, `trip_i` is ignored for BLANK_CYCLES cycles. With `trip_i` held high, every drive pulse therefore lasts BLANK_CYCLES+2 cycles.
- R9: The drive pattern returns in the cycle right after the last cycle of the off period.
- R10: When `enable_n_i` or `halt_i` is sampled high, all gates are low from the next cycle on for as long as either stays high, and `trip_i` has no effect. After both go low, the drive pattern returns in the second cycle and any unfinished off period is abandoned.
- R11: No leg ever has its source and sink on together. A gate turns on only if both gates of its leg were off in the cycle before, so reversing the polarity while driving produces exactly one all-off cycle.
- R12: `decay_i` = 11 behaves the same as slow decay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Current comparator; high means the trip level has been reached |
| decay_i | input | 2 | Decay mode: 00 slow, 01 fast, 10 mixed, 11 slow |
| polarity_i | input | 1 | Winding current direction |
| enable_n_i | input | 1 | Active-low output enable |
| halt_i | input | 1 | Fault or sleep request; forces the gates off |
| src_a_o | output | 1 | High-side switch, leg A |
| snk_a_o | output | 1 | Low-side switch, leg A |
| src_b_o | output | 1 | High-side switch, leg B |
| snk_b_o | output | 1 | Low-side switch, leg B |

## Verification
The main instance is built with OFF_CYCLES 12, BLANK_CYCLES 3 and FAST_CYCLES 5. With these values a full chop period fits in about twenty cycles, and a mixed off period has both a fast portion and a slow portion that can be measured separately. A second instance uses FAST_CYCLES 20, which is longer than its 12-cycle off period, so the clamp makes the whole off period fast decay. Random trip, mode, polarity, enable and hold activity tests leg exclusivity, dead cycles and forced-off behaviour in many combinations that the directed cases do not reach.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int LEGS = 2;

  typedef enum logic [1:0] {
    DCY_SLOW     = 2'b00,
    DCY_FAST     = 2'b01,
    DCY_MIXED    = 2'b10,
    DCY_SLOW_ALT = 2'b11
  } decay_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ON   = 2'b01,
    PH_OFF  = 2'b10
  } phase_e;

  // per leg: bit 1 = source (high side), bit 0 = sink (low side); index 1 = leg A
  typedef logic [LEGS-1:0][1:0] gates_t;

  function automatic gates_t drive_pattern(input logic pol);
    gates_t p;
    p = pol ? {2'b01, 2'b10} : {2'b10, 2'b01};
    return p;
  endfunction

  function automatic gates_t sink_pattern(input logic pol);
    gates_t p;
    p = pol ? {2'b01, 2'b00} : {2'b00, 2'b01};
    return p;
  endfunction
endpackage

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int OFF_CYC  = 12,
  parameter int FAST_CYC = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run_i,
  input  logic   trip_i,
  input  logic   armed_i,
  output phase_e phase_o,
  output logic   fast_win_o
);
  localparam int CNT_W    = $clog2(OFF_CYC + 1);
  localparam int FAST_EFF = (FAST_CYC > OFF_CYC) ? OFF_CYC : FAST_CYC;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_EFF);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: ph <= PH_ON;
        PH_ON: begin
          if (trip_i && armed_i) begin
            ph  <= PH_OFF;
            cnt <= '0;
          end
        end
        PH_OFF: begin
          if (cnt == LAST) begin
            ph  <= PH_ON;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = ph;
  assign fast_win_o = (ph == PH_OFF) && (cnt < FAST_LIM);

  // R6: the off period cannot be cut short while enabled
  a_r6_off_hold: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_OFF && cnt != LAST && run_i) |=> (ph == PH_OFF));

  // R9: the final off cycle leads straight back into driving
  a_r9_reenter: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_OFF && cnt == LAST && run_i) |=> (ph == PH_ON));

  // R8: an unarmed comparator never ends the drive phase
  a_r8_blank_hold: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ON && !armed_i) |=> (ph != PH_OFF));
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
  import chop_pkg::*;
(
  input  phase_e phase_i,
  input  logic   fast_win_i,
  input  logic   pol_i,
  input  decay_e decay_i,
  output gates_t tgt_o
);
  always_comb begin
    tgt_o = '0;
    case (phase_i)
      PH_ON:  tgt_o = drive_pattern(pol_i);
      PH_OFF: begin
        case (decay_i)
          DCY_FAST:  tgt_o = '0;
          DCY_MIXED: tgt_o = fast_win_i ? '0 : sink_pattern(pol_i);
          default:   tgt_o = sink_pattern(pol_i);
        endcase
      end
      default: tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/chop_gate_out.sv
module chop_gate_out
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run_i,
  input  gates_t tgt_i,
  output gates_t gates_o,
  output logic   armed_o
);
  localparam int BLK_W = $clog2(BLANK_CYC + 1);
  localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_CYC);

  gates_t           g;
  gates_t           nxt;
  logic [BLK_W-1:0] blk;

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    // a leg that must swap its conducting switch passes through all-off first
    assign nxt[l] = !run_i ? 2'b00 :
                    ((g[l] != 2'b00) && (tgt_i[l] != 2'b00) && (g[l] != tgt_i[l])) ? 2'b00 :
                    tgt_i[l];

    // R11: source and sink of one leg never on together
    a_r11_no_shoot: assert property (@(posedge clk) disable iff (rst)
      g[l] != 2'b11);

    // R11: a switch turns on only out of an all-off leg
    a_r11_dead_cycle: assert property (@(posedge clk) disable iff (rst)
      ($rose(g[l][1]) || $rose(g[l][0])) |-> ($past(g[l]) == 2'b00));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g   <= '0;
      blk <= '0;
    end else begin
      g <= nxt;
      if (nxt != g)        blk <= BLK_LOAD;
      else if (blk != '0)  blk <= blk - 1'b1;
    end
  end

  assign gates_o = g;
  assign armed_o = (blk == '0) && (g == tgt_i);

  // R10: disable or hold forces every gate off in the next cycle
  a_r10_force_off: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (g == '0));
endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 200,
  parameter int BLANK_CYCLES = 25,
  parameter int FAST_CYCLES  = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trip_i,
  input  logic [1:0] decay_i,
  input  logic       polarity_i,
  input  logic       enable_n_i,
  input  logic       halt_i,
  output logic       src_a_o,
  output logic       snk_a_o,
  output logic       src_b_o,
  output logic       snk_b_o
);
  logic   run;
  phase_e phase;
  logic   fast_win;
  logic   armed;
  gates_t tgt;
  gates_t gates;

  assign run = !enable_n_i && !halt_i;

  chop_seq #(
    .OFF_CYC  (OFF_CYCLES),
    .FAST_CYC (FAST_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run),
    .trip_i     (trip_i),
    .armed_i    (armed),
    .phase_o    (phase),
    .fast_win_o (fast_win)
  );

  chop_gate_map u_map (
    .phase_i    (phase),
    .fast_win_i (fast_win),
    .pol_i      (polarity_i),
    .decay_i    (decay_e'(decay_i)),
    .tgt_o      (tgt)
  );

  chop_gate_out #(
    .BLANK_CYC (BLANK_CYCLES)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .tgt_i   (tgt),
    .gates_o (gates),
    .armed_o (armed)
  );

  assign {src_a_o, snk_a_o, src_b_o, snk_b_o} = gates;
endmodule

// File: tb/chop_bridge_ctrl_bench.sv
`timescale 1ns/1ps
module chop_bridge_ctrl_bench;
  localparam int OFFC = 12;
  localparam int BLKC = 3;
  localparam int FSTC = 5;
  localparam logic [3:0] ON0 = 4'b1001, ON1 = 4'b0110;
  localparam logic [3:0] SLW0 = 4'b0001, SLW1 = 4'b0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 1'b0;
  logic [1:0] dcy = 2'b00;
  logic pol = 1'b0;
  logic en_n = 1'b0;
  logic halt = 1'b0;
  logic a_src, a_snk, b_src, b_snk;
  logic c_src_a, c_snk_a, c_src_b, c_snk_b;
  logic [3:0] g1, g2;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chop_bridge_ctrl #(.OFF_CYCLES(OFFC), .BLANK_CYCLES(BLKC), .FAST_CYCLES(FSTC)) u_chop_bridge_ctrl (
    .clk(clk), .rst(rst), .trip_i(trip), .decay_i(dcy), .polarity_i(pol),
    .enable_n_i(en_n), .halt_i(halt),
    .src_a_o(a_src), .snk_a_o(a_snk), .src_b_o(b_src), .snk_b_o(b_snk));

  chop_bridge_ctrl #(.OFF_CYCLES(OFFC), .BLANK_CYCLES(BLKC), .FAST_CYCLES(20)) u_chop_bridge_ctrl_clamp (
    .clk(clk), .rst(rst), .trip_i(trip), .decay_i(dcy), .polarity_i(pol),
    .enable_n_i(en_n), .halt_i(halt),
    .src_a_o(c_src_a), .snk_a_o(c_snk_a), .src_b_o(c_src_b), .snk_b_o(c_snk_b));

  assign g1 = {a_src, a_snk, b_src, b_snk};
  assign g2 = {c_src_a, c_snk_a, c_src_b, c_snk_b};

  function automatic logic [3:0] drive_pat(input logic p);
    return p ? ON1 : ON0;
  endfunction

  function automatic logic [3:0] slow_pat(input logic p);
    return p ? SLW1 : SLW0;
  endfunction

  function automatic bit no_shoot(input logic [3:0] c);
    return (c[3:2] != 2'b11) && (c[1:0] != 2'b11);
  endfunction

  function automatic bit dead_ok(input logic [3:0] p, input logic [3:0] c);
    bit ok = 1'b1;
    if (((c[3:2] & ~p[3:2]) != 2'b00) && (p[3:2] != 2'b00)) ok = 1'b0;
    if (((c[1:0] & ~p[1:0]) != 2'b00) && (p[1:0] != 2'b00)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [3:0] gsel(input bit sel);
    return sel ? g2 : g1;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_len(input bit sel, input logic [3:0] pat, output int n);
    n = 0;
    while (gsel(sel) == pat && n < 500) begin
      n++;
      step();
    end
  endtask

  task automatic do_reset(input logic tr, input logic [1:0] dc, input logic pl);
    rst = 1'b1; en_n = 1'b0; halt = 1'b0; trip = tr; dcy = dc; pol = pl;
    step(3);
    check_eq("R1 gates in reset", int'(g1), 0);
    check_eq("R1 gates in reset (clamp)", int'(g2), 0);
    rst = 1'b0;
    step();
    check_eq("R1 first cycle after reset", int'(g1), 0);
    step();
    check_eq("R2 drive after reset", int'(gsel(1'b0)), int'(drive_pat(pl)));
  endtask

  // one chop period with trip held high
  task automatic chop_period(input bit sel, input logic [1:0] dc, input logic pl,
                             input int exp_fast, input int exp_slow, input string tag);
    int n;
    do_reset(1'b1, dc, pl);
    check_eq({tag, " drive pattern"}, int'(gsel(sel)), int'(drive_pat(pl)));
    run_len(sel, drive_pat(pl), n);
    check_eq("R8 drive width under constant trip", n, BLKC + 2);
    if (exp_fast > 0) begin
      run_len(sel, 4'b0000, n);
      check_eq({tag, " fast portion"}, n, exp_fast);
    end
    if (exp_slow > 0) begin
      run_len(sel, slow_pat(pl), n);
      check_eq({tag, " slow portion"}, n, exp_slow);
    end
    check_eq("R9 drive resumes after off period", int'(gsel(sel)), int'(drive_pat(pl)));
  endtask

  initial begin
    int n;
    logic [3:0] p1, p2, c1, c2;
    bit prev_run;
    step(2);

    // decay modes, both polarities, clamp
    chop_period(1'b0, 2'b00, 1'b0, 0, OFFC, "R4 R6 slow pol0");
    chop_period(1'b0, 2'b00, 1'b1, 0, OFFC, "R4 slow pol1");
    chop_period(1'b0, 2'b01, 1'b0, OFFC, 0, "R5 fast");
    chop_period(1'b0, 2'b10, 1'b0, FSTC, OFFC - FSTC, "R7 mixed");
    chop_period(1'b1, 2'b10, 1'b1, OFFC, 0, "R7 mixed clamp");
    chop_period(1'b0, 2'b11, 1'b0, 0, OFFC, "R12 code 11");

    // trip latency, fixed off period, blanking
    do_reset(1'b0, 2'b00, 1'b0);
    step(20);
    check_eq("R2 drive held without trip", int'(g1), int'(ON0));
    trip = 1'b1;
    step();
    check_eq("R3 drive one cycle after trip", int'(g1), int'(ON0));
    trip = 1'b0;
    step();
    check_eq("R3 decay two cycles after trip", int'(g1), int'(SLW0));
    run_len(1'b0, SLW0, n);
    check_eq("R6 off length with trip low", n, OFFC);
    check_eq("R9 drive after off period", int'(g1), int'(ON0));
    trip = 1'b1;
    step(BLKC);
    trip = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check_eq("R8 trip in blanking ignored", int'(g1), int'(ON0));
      step();
    end

    // polarity reversal while driving
    pol = 1'b1;
    step();
    check_eq("R11 dead cycle on reversal", int'(g1), 0);
    step();
    check_eq("R11 reversed drive", int'(g1), int'(ON1));

    // output enable
    step(6);
    en_n = 1'b1;
    step();
    check_eq("R10 disable forces off", int'(g1), 0);
    for (int i = 0; i < 8; i++) begin
      trip = ~trip;
      step();
      check_eq("R10 stays off while disabled", int'(g1), 0);
    end
    trip = 1'b0; en_n = 1'b0;
    step();
    check_eq("R10 off one cycle after enable", int'(g1), 0);
    step();
    check_eq("R10 drive returns after enable", int'(g1), int'(ON1));

    // hold request during off period
    step(6);
    trip = 1'b1;
    step();
    trip = 1'b0;
    step();
    check_eq("R4 slow pol1 before hold", int'(g1), int'(SLW1));
    halt = 1'b1;
    step();
    check_eq("R10 hold forces off", int'(g1), 0);
    step(4);
    check_eq("R10 hold keeps off", int'(g1), 0);
    halt = 1'b0;
    step();
    check_eq("R10 off one cycle after hold", int'(g1), 0);
    step();
    check_eq("R10 off period abandoned", int'(g1), int'(ON1));

    // constrained random phase
    void'($urandom(32'h0C40_55ED));
    do_reset(1'b0, 2'b10, 1'b0);
    p1 = g1; p2 = g2; prev_run = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      c1 = g1; c2 = g2;
      check_eq("R11 no shoot-through", int'(no_shoot(c1) && no_shoot(c2)), 1);
      check_eq("R11 dead cycle before turn-on", int'(dead_ok(p1, c1) && dead_ok(p2, c2)), 1);
      if (!prev_run) begin
        check_eq("R10 off while disabled or held", int'(c1), 0);
        check_eq("R10 off while disabled or held (clamp)", int'(c2), 0);
      end
      trip = ($urandom % 100) < 30;
      if (($urandom % 100) < 5) dcy = 2'($urandom % 4);
      if (($urandom % 100) < 3) pol = ~pol;
      if (($urandom % 100) < 2) en_n = 1'b1;
      else if (($urandom % 100) < 20) en_n = 1'b0;
      if (($urandom % 100) < 2) halt = 1'b1;
      else if (($urandom % 100) < 20) halt = 1'b0;
      prev_run = !en_n && !halt;
      p1 = c1; p2 = c2;
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule